// File: doc/BRIEF.md
# DMA Channel Start Control

This block is the control and status front end of one DMA channel. A CPU writes a small register set through a simple write port and reads it back through a registered read port. The register set holds a channel mode word and a 36-bit descriptor pointer split across two registers. From these writes the block sends one-clock start and abort pulses to the transfer engine and tracks a busy flag. The engine reports back with done and error strobes.

Software launches a transfer by clearing and then setting the go bit. A single-write-start option lets one write of the lower pointer register do the launch, after software has written the upper pointer bits. The pointer is captured at launch and held steady on `desc_ptr` for the rest of the transfer. Software can stop a running transfer by raising the halt bit.

Top module: `dma_chan_ctl`

## Requirements
- R1: After a synchronous reset, `busy`, `start_pulse`, `abort_pulse` and `done_pulse` are 0, and every register reads 0.
- R2: Register map, with `rd_data` valid one clock after `rd_addr` is presented. Address 0 is the mode word: bit 0 go, bit 1 halt, bit 2 direct (1 = direct transfer, 0 = chained), bit 3 extended enable, bit 4 single-write-start. Address 1 holds pointer bits 35:32 in data bits 3:0. Address 2 holds pointer bits 31:0. Address 3 is status, with busy in bit 0, and writes to it are ignored. `direct_mode` and `ext_mode` follow mode bits 2 and 3.
- R3: A mode write that takes go from 0 to 1 while idle raises `start_pulse` and `busy` at the clock edge that takes the write. At that edge `desc_ptr` becomes {upper, lower}.
- R4: A mode write with go set, when go is already 1, does not launch.
- R5: When both single-write-start and extended enable are 1, a write to address 2 sets the go bit and launches. `desc_ptr` then carries the newly written lower bits together with the upper bits written earlier.
- R6: When single-write-start is 1 but extended enable is 0, a write to address 2 only stores the value. It does not launch.
- R7: A start event while busy is ignored: no `start_pulse`, and `desc_ptr` does not change.
- R8: While busy, `eng_done` or `eng_err` clears `busy` at the next edge and gives a one-clock `done_pulse`.
- R9: A 0-to-1 change of the halt bit while busy gives a one-clock `abort_pulse` and a `done_pulse`, and clears `busy`, all at the edge that takes the write. A halt bit that is already set, or a halt edge while idle, gives no abort.
- R10: Each of `start_pulse`, `abort_pulse` and `done_pulse` lasts exactly one clock. `desc_ptr` is stable while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Registered read data |
| eng_done | input | 1 | Engine reports the last descriptor finished |
| eng_err | input | 1 | Engine reports an error |
| start_pulse | output | 1 | One-clock launch request to the engine |
| abort_pulse | output | 1 | One-clock abort request to the engine |
| done_pulse | output | 1 | One-clock pulse when busy ends |
| busy | output | 1 | Transfer in progress |
| desc_ptr | output | PTR_W | Descriptor pointer captured at launch |
| direct_mode | output | 1 | Direct transfer selected (0 = chained) |
| ext_mode | output | 1 | Extended features enabled |

## Verification
The bench rewrites the mode word with go already high. A design that treated level instead of edge would launch again. It drives single-write-start with and without extended enable. A design that ignored the enable would launch on a plain pointer write, and one that latched the old lower pointer would hand a stale address to the engine. It repeats start and halt edges during a running transfer, and halt edges while idle and with halt already high. A design that got these wrong would restart a busy channel, corrupt `desc_ptr`, or abort a channel that was not running. The pulse width checks catch outputs that stick high.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_MODE = 2'd0,
    RA_PHI  = 2'd1,
    RA_PLO  = 2'd2,
    RA_STAT = 2'd3
  } reg_addr_e;

  localparam int MODE_W = 5;

  // bit 4 .. bit 0
  typedef struct packed {
    logic sws;
    logic ext;
    logic direct;
    logic halt;
    logic go;
  } mode_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;
endpackage

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic              busy,
  output mode_t             mode_o,
  output logic [PTR_W-1:0]  ptr_next,
  output logic              start_evt,
  output logic              abort_evt,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HI_W = PTR_W - DATA_W;

  mode_t             mode_q;
  logic [HI_W-1:0]   hi_q;
  logic [DATA_W-1:0] lo_q;
  mode_t             new_mode;
  logic              wr_mode, wr_hi, wr_lo, auto_go;

  always_comb begin
    wr_mode   = wr_en && (wr_addr == RA_MODE);
    wr_hi     = wr_en && (wr_addr == RA_PHI);
    wr_lo     = wr_en && (wr_addr == RA_PLO);
    new_mode  = mode_t'(wr_data[MODE_W-1:0]);
    auto_go   = wr_lo && mode_q.sws && mode_q.ext;
    start_evt = (wr_mode && new_mode.go && !mode_q.go) || auto_go;
    abort_evt = wr_mode && new_mode.halt && !mode_q.halt;
    ptr_next  = {hi_q, (wr_lo ? wr_data : lo_q)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      if (wr_mode)
        mode_q <= new_mode;
      else if (auto_go)
        mode_q.go <= 1'b1;
      if (wr_hi) hi_q <= wr_data[HI_W-1:0];
      if (wr_lo) lo_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        RA_MODE: rd_data <= {{(DATA_W-MODE_W){1'b0}}, mode_q};
        RA_PHI:  rd_data <= {{(DATA_W-HI_W){1'b0}}, hi_q};
        RA_PLO:  rd_data <= lo_q;
        default: rd_data <= {{(DATA_W-1){1'b0}}, busy};
      endcase
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/dma_ctl_launch.sv
module dma_ctl_launch
  import dma_ctl_pkg::*;
#(
  parameter int PTR_W = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_evt,
  input  logic             abort_evt,
  input  logic             eng_done,
  input  logic             eng_err,
  input  logic [PTR_W-1:0] ptr_next,
  output logic             busy,
  output logic             start_pulse,
  output logic             abort_pulse,
  output logic             done_pulse,
  output logic [PTR_W-1:0] launch_ptr
);
  run_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      start_pulse <= 1'b0;
      abort_pulse <= 1'b0;
      done_pulse  <= 1'b0;
      launch_ptr  <= '0;
    end else begin
      start_pulse <= 1'b0;
      abort_pulse <= 1'b0;
      done_pulse  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_evt) begin
            state_q     <= ST_RUN;
            start_pulse <= 1'b1;
            launch_ptr  <= ptr_next;
          end
        end
        default: begin
          if (abort_evt) begin
            state_q     <= ST_IDLE;
            abort_pulse <= 1'b1;
            done_pulse  <= 1'b1;
          end else if (eng_done || eng_err) begin
            state_q    <= ST_IDLE;
            done_pulse <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy = (state_q == ST_RUN);
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              eng_done,
  input  logic              eng_err,
  output logic              start_pulse,
  output logic              abort_pulse,
  output logic              done_pulse,
  output logic              busy,
  output logic [PTR_W-1:0]  desc_ptr,
  output logic              direct_mode,
  output logic              ext_mode
);
  mode_t            mode_w;
  logic [PTR_W-1:0] ptr_next_w;
  logic             start_evt_w, abort_evt_w, busy_w;

  dma_ctl_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .busy      (busy_w),
    .mode_o    (mode_w),
    .ptr_next  (ptr_next_w),
    .start_evt (start_evt_w),
    .abort_evt (abort_evt_w),
    .rd_data   (rd_data)
  );

  dma_ctl_launch #(.PTR_W(PTR_W)) u_launch (
    .clk         (clk),
    .rst         (rst),
    .start_evt   (start_evt_w),
    .abort_evt   (abort_evt_w),
    .eng_done    (eng_done),
    .eng_err     (eng_err),
    .ptr_next    (ptr_next_w),
    .busy        (busy_w),
    .start_pulse (start_pulse),
    .abort_pulse (abort_pulse),
    .done_pulse  (done_pulse),
    .launch_ptr  (desc_ptr)
  );

  assign busy        = busy_w;
  assign direct_mode = mode_w.direct;
  assign ext_mode    = mode_w.ext;
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk #(
  parameter int PTR_W = 36
) (
  input logic             clk,
  input logic             rst,
  input logic             eng_done,
  input logic             eng_err,
  input logic             start_pulse,
  input logic             abort_pulse,
  input logic             done_pulse,
  input logic             busy,
  input logic [PTR_W-1:0] desc_ptr
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> busy) else $error("start without busy"); // R3
  AST_BUSY_RISES_ON_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> start_pulse) else $error("busy rose without start"); // R3
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> !$past(busy)) else $error("restart while busy"); // R7
  AST_ENGINE_END: assert property (@(posedge clk) disable iff (rst)
    (busy && (eng_done || eng_err)) |=> (!busy && done_pulse)) else $error("engine end missed"); // R8
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |-> (!busy && done_pulse && $past(busy))) else $error("abort bad"); // R9
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done_pulse) else $error("busy fell silently"); // R8
  AST_START_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse) else $error("start wide"); // R10
  AST_ABORT_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |=> !abort_pulse) else $error("abort wide"); // R10
  AST_DONE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse) else $error("done wide"); // R10
  AST_PTR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy && !start_pulse) |-> $stable(desc_ptr)) else $error("ptr moved"); // R10
endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .eng_done    (eng_done),
  .eng_err     (eng_err),
  .start_pulse (start_pulse),
  .abort_pulse (abort_pulse),
  .done_pulse  (done_pulse),
  .busy        (busy),
  .desc_ptr    (desc_ptr)
);

// File: tb/tb_dma_chan_ctl.sv
module tb_dma_chan_ctl;
  localparam int DATA_W = 32;
  localparam int PTR_W  = 36;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [1:0]        rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              eng_done = 1'b0, eng_err = 1'b0;
  logic              start_pulse, abort_pulse, done_pulse, busy;
  logic [PTR_W-1:0]  desc_ptr;
  logic              direct_mode, ext_mode;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dma_chan_ctl #(.DATA_W(DATA_W), .PTR_W(PTR_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .eng_done(eng_done), .eng_err(eng_err),
    .start_pulse(start_pulse), .abort_pulse(abort_pulse), .done_pulse(done_pulse),
    .busy(busy), .desc_ptr(desc_ptr), .direct_mode(direct_mode), .ext_mode(ext_mode)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write takes effect at the edge between the two negedges
  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic t_reset;
    logic [DATA_W-1:0] v;
    check("R1 busy", busy, 0);
    check("R1 pulses", {start_pulse, abort_pulse, done_pulse}, 0);
    for (int i = 0; i < 4; i++) begin
      rd(i[1:0], v);
      check("R1 reg", v, 0);
    end
  endtask

  task automatic t_regs;
    logic [DATA_W-1:0] v;
    wr(2'd1, 32'hFFFF_FFF5); rd(2'd1, v); check("R2 hi", v, 32'h5);
    wr(2'd2, 32'h1234_5678); rd(2'd2, v); check("R2 lo", v, 32'h1234_5678);
    check("R2 no launch", busy, 0);
    wr(2'd0, 32'h0C); rd(2'd0, v); check("R2 mode", v, 32'h0C);
    check("R2 mode pins", {direct_mode, ext_mode}, 2'b11);
    wr(2'd3, 32'h1); rd(2'd3, v); check("R2 status write ignored", v, 0);
  endtask

  task automatic t_start_done;
    logic [DATA_W-1:0] v;
    wr(2'd0, 32'h0D);
    check("R3 start", start_pulse, 1);
    check("R3 busy", busy, 1);
    check("R3 ptr", desc_ptr, 36'h5_1234_5678);
    rd(2'd3, v); check("R2 status busy", v, 1);
    check("R10 start width", start_pulse, 0);
    wr(2'd0, 32'h0C); wr(2'd0, 32'h0D);
    check("R7 restart ignored", start_pulse, 0);
    wr(2'd2, 32'hDEAD_BEEF);
    check("R7 ptr held", desc_ptr, 36'h5_1234_5678);
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    check("R8 done clears busy", busy, 0);
    check("R8 done pulse", done_pulse, 1);
    @(negedge clk);
    check("R10 done width", done_pulse, 0);
    wr(2'd0, 32'h0D);
    check("R4 level go no launch", {start_pulse, busy}, 0);
  endtask

  task automatic t_auto;
    logic [DATA_W-1:0] v;
    wr(2'd0, 32'h18);
    wr(2'd1, 32'hA);
    check("R5 no launch on hi", busy, 0);
    wr(2'd2, 32'hCAFE_F00D);
    check("R5 auto start", start_pulse, 1);
    check("R5 auto ptr", desc_ptr, 36'hA_CAFE_F00D);
    rd(2'd0, v); check("R5 go set", v, 32'h19);
    @(negedge clk); eng_err = 1'b1;
    @(negedge clk); eng_err = 1'b0;
    check("R8 error clears busy", {busy, done_pulse}, 2'b01);
    wr(2'd0, 32'h10);
    wr(2'd2, 32'h0000_0042);
    check("R6 no auto without ext", {start_pulse, busy}, 0);
    rd(2'd0, v); check("R6 go stays clear", v, 32'h10);
    check("R6 desc_ptr unchanged", desc_ptr, 36'hA_CAFE_F00D);
  endtask

  task automatic t_abort;
    wr(2'd0, 32'h00);
    wr(2'd0, 32'h01);
    check("R3 launch", busy, 1);
    wr(2'd0, 32'h03);
    check("R9 abort", {abort_pulse, done_pulse, busy}, 3'b110);
    @(negedge clk);
    check("R10 abort width", abort_pulse, 0);
    wr(2'd0, 32'h02);
    wr(2'd0, 32'h03);
    check("R9 launch with halt high", busy, 1);
    wr(2'd0, 32'h03);
    check("R9 held halt no abort", {abort_pulse, busy}, 2'b01);
    wr(2'd0, 32'h01);
    wr(2'd0, 32'h03);
    check("R9 second abort", {abort_pulse, busy}, 2'b10);
    wr(2'd0, 32'h00);
    wr(2'd0, 32'h02);
    check("R9 idle halt ignored", {abort_pulse, done_pulse, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_start_done();
    t_auto();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule